// File: doc/BRIEF.md
# Crank-Synchronous Injection and Ignition Event Scheduler

This block drives the injector and ignition coil outputs for up to eight engine cylinders from a single crank-angle tick counter that all cylinders share. A supervising processor writes a few shared values, such as a reference tick, the injector pulse length and the coil dwell. It also writes a phase offset, a fuel trim and a spark trim for each cylinder. From these the block works out four compare points per cylinder for one full 720-degree cycle. It raises and lowers the outputs when the shared counter reaches each point.

Configuration goes through a plain write port with address, data and write enable. All written values land in shadow registers. A write to the commit address moves every shadow value into the live compare points in one clock edge, so an on/off pair can never be only half updated. Each event fires at most once per cycle. An event whose new compare point is already behind the counter when it is committed, and that has not yet fired in this cycle, fires on the next clock and is flagged as late. It is not deferred by a whole cycle.

Top module: `crank_event_sched`

## Requirements
- R1: For each cylinder c, `inj_o[c]` rises when the injector-on point fires and falls when the injector-off point fires. `coil_o[c]` rises at the dwell-start point and falls at the spark point.
- R2: `tick_cnt_o` holds while `tick_i` is low. On an armed clock with `tick_i` high it advances by one, and after reaching modulus-1 it returns to 0. The modulus is the committed value of address 0 and is 720 after reset.
- R3: All arithmetic is modulo the modulus, with every written value taken to be below it. Each cylinder has start = base(addr 1) + offset. Injector-on = start. Injector-off = start + pulse length(addr 2) + fuel trim. Spark = start + spark trim. Dwell-start = spark - dwell(addr 3). Cylinder c keeps its offset at 8+4c, its fuel trim at 9+4c and its spark trim at 10+4c.
- R4: An event that has not yet fired in the current cycle fires on the first clock edge at which the registered count is greater than or equal to its point. Its output therefore changes one clock after the counter reaches the point. The fired record of every event is cleared on the edge where the counter wraps.
- R5: After a commit, an event whose point is behind the count and that has not fired in this cycle fires on the next clock. `late_o[c]` is high for exactly that one clock.
- R6: Writes to addresses 0 to 3 and to the per-cylinder addresses have no effect on the outputs until address 4 is written. The data of the commit write is ignored.
- R7: If a pair's on point equals its off point, that output stays low. `err_cnt_o` goes up by one each time such a pair fires and saturates at its maximum.
- R8: When the on event and the off event of one output fire on the same edge, the output ends low.
- R9: After reset, and until the first commit, the counter stays at 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Crank-angle tick, one clock wide per tick |
| wr_en_i | input | 1 | Configuration write enable |
| wr_addr_i | input | AW | Configuration register address |
| wr_data_i | input | TW | Configuration write data |
| tick_cnt_o | output | TW | Shared crank tick count |
| inj_o | output | N_CYL | Injector drive per cylinder |
| coil_o | output | N_CYL | Ignition coil drive per cylinder |
| late_o | output | N_CYL | One-clock flag for a late-fired event |
| err_cnt_o | output | ERR_W | Saturating count of equal on/off pairs |

## Verification
The bench runs a behavioural model next to the design and goes after the wrap boundary, where a dwell that starts late in one cycle must end with a spark at tick 0 of the next. A design that cleared its fired flags on the wrong edge would either drop that spark or fire it twice. The bench also moves a cylinder's start point behind the counter and commits it. A design without the catch-up rule would leave the injector dark for a whole cycle, and one that used equality matching would never fire it. Further cases are a pair whose on and off points both lie behind the count, which must leave the output low with a late flag, and an equal on/off pair, which must keep the output low and bump the error count exactly once per cycle. A shadow write with no commit must not move any edge.

// File: rtl/crank_sched_pkg.sv
package crank_sched_pkg;
  localparam int unsigned EV_N = 4;
  localparam int unsigned E_INJ_ON  = 0;
  localparam int unsigned E_INJ_OFF = 1;
  localparam int unsigned E_DWELL   = 2;
  localparam int unsigned E_SPARK   = 3;

  localparam int unsigned A_MOD    = 0;
  localparam int unsigned A_BASE   = 1;
  localparam int unsigned A_INJW   = 2;
  localparam int unsigned A_DWELL  = 3;
  localparam int unsigned A_COMMIT = 4;
  localparam int unsigned A_CYL0   = 8;
  localparam int unsigned CYL_STRIDE = 4;
  localparam int unsigned R_OFS  = 0;
  localparam int unsigned R_FUEL = 1;
  localparam int unsigned R_SPK  = 2;
endpackage

// File: rtl/crank_cfg_regs.sv
module crank_cfg_regs
  import crank_sched_pkg::*;
#(
  parameter int unsigned N_CYL = 4,
  parameter int unsigned TW = 16,
  parameter int unsigned AW = 5,
  parameter logic [TW-1:0] DEF_MOD = 720
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [TW-1:0] wr_data_i,
  output logic armed_o,
  output logic [TW-1:0] mod_o,
  output logic [N_CYL-1:0][EV_N-1:0][TW-1:0] pts_o
);
  logic [TW-1:0] mod_sh, base_sh, injw_sh, dwell_sh;
  logic [N_CYL-1:0][TW-1:0] ofs_sh, fuel_sh, spk_sh;
  logic [N_CYL-1:0][EV_N-1:0][TW-1:0] pts_nxt;
  logic commit;

  function automatic logic [TW-1:0] madd(logic [TW-1:0] a, logic [TW-1:0] b, logic [TW-1:0] m);
    logic [TW:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, m}) s = s - {1'b0, m};
    return s[TW-1:0];
  endfunction

  function automatic logic [TW-1:0] msub(logic [TW-1:0] a, logic [TW-1:0] b, logic [TW-1:0] m);
    if (a >= b) return a - b;
    return a + m - b;
  endfunction

  assign commit = wr_en_i && (wr_addr_i == AW'(A_COMMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_sh   <= DEF_MOD;
      base_sh  <= '0;
      injw_sh  <= '0;
      dwell_sh <= '0;
      ofs_sh   <= '0;
      fuel_sh  <= '0;
      spk_sh   <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == AW'(A_MOD))   mod_sh   <= wr_data_i;
      if (wr_addr_i == AW'(A_BASE))  base_sh  <= wr_data_i;
      if (wr_addr_i == AW'(A_INJW))  injw_sh  <= wr_data_i;
      if (wr_addr_i == AW'(A_DWELL)) dwell_sh <= wr_data_i;
      for (int c = 0; c < N_CYL; c++) begin
        if (wr_addr_i == AW'(A_CYL0 + CYL_STRIDE*c + R_OFS))  ofs_sh[c]  <= wr_data_i;
        if (wr_addr_i == AW'(A_CYL0 + CYL_STRIDE*c + R_FUEL)) fuel_sh[c] <= wr_data_i;
        if (wr_addr_i == AW'(A_CYL0 + CYL_STRIDE*c + R_SPK))  spk_sh[c]  <= wr_data_i;
      end
    end
  end

  for (genvar c = 0; c < N_CYL; c++) begin : g_pts
    logic [TW-1:0] start, spark;
    assign start = madd(base_sh, ofs_sh[c], mod_sh);
    assign spark = madd(start, spk_sh[c], mod_sh);
    assign pts_nxt[c][E_INJ_ON]  = start;
    assign pts_nxt[c][E_INJ_OFF] = madd(madd(start, injw_sh, mod_sh), fuel_sh[c], mod_sh);
    assign pts_nxt[c][E_SPARK]   = spark;
    assign pts_nxt[c][E_DWELL]   = msub(spark, dwell_sh, mod_sh);
  end

  // live set changes only on commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      mod_o   <= DEF_MOD;
      pts_o   <= '0;
    end else if (commit) begin
      armed_o <= 1'b1;
      mod_o   <= mod_sh;
      pts_o   <= pts_nxt;
    end
  end
endmodule

// File: rtl/crank_tick_ctr.sv
module crank_tick_ctr #(
  parameter int unsigned TW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic tick_i,
  input  logic [TW-1:0] mod_i,
  output logic [TW-1:0] cnt_o,
  output logic wrap_o
);
  logic step;
  assign step   = armed_i && tick_i;
  assign wrap_o = step && (({1'b0, cnt_o} + 1'b1) >= {1'b0, mod_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (wrap_o) cnt_o <= '0;
    else if (step)   cnt_o <= cnt_o + TW'(1);
  end
endmodule

// File: rtl/crank_event_chan.sv
module crank_event_chan
  import crank_sched_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic wrap_i,
  input  logic [TW-1:0] cnt_i,
  input  logic [EV_N-1:0][TW-1:0] pts_i,
  output logic inj_o,
  output logic coil_o,
  output logic late_o,
  output logic [1:0] err_hit_o
);
  logic [EV_N-1:0] done_q, fire, behind;

  for (genvar e = 0; e < EV_N; e++) begin : g_ev
    assign fire[e]   = armed_i && !done_q[e] && (pts_i[e] <= cnt_i);
    assign behind[e] = fire[e] && (pts_i[e] < cnt_i);
  end

  assign err_hit_o[0] = fire[E_INJ_ON] && (pts_i[E_INJ_ON] == pts_i[E_INJ_OFF]);
  assign err_hit_o[1] = fire[E_DWELL]  && (pts_i[E_DWELL]  == pts_i[E_SPARK]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
      inj_o  <= 1'b0;
      coil_o <= 1'b0;
      late_o <= 1'b0;
    end else begin
      done_q <= wrap_i ? '0 : (done_q | fire);
      late_o <= |behind;
      // off wins over on in the same edge
      if (fire[E_INJ_OFF])     inj_o <= 1'b0;
      else if (fire[E_INJ_ON]) inj_o <= 1'b1;
      if (fire[E_SPARK])       coil_o <= 1'b0;
      else if (fire[E_DWELL])  coil_o <= 1'b1;
    end
  end
endmodule

// File: rtl/crank_event_sched.sv
module crank_event_sched
  import crank_sched_pkg::*;
#(
  parameter int unsigned N_CYL = 4,
  parameter int unsigned TW = 16,
  parameter int unsigned ERR_W = 8,
  parameter logic [TW-1:0] DEF_MOD = 720,
  parameter int unsigned AW = $clog2(A_CYL0 + CYL_STRIDE*N_CYL)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [TW-1:0] wr_data_i,
  output logic [TW-1:0] tick_cnt_o,
  output logic [N_CYL-1:0] inj_o,
  output logic [N_CYL-1:0] coil_o,
  output logic [N_CYL-1:0] late_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  localparam int unsigned SW = ERR_W + 5;

  logic armed, wrap;
  logic [TW-1:0] mod_q;
  logic [N_CYL-1:0][EV_N-1:0][TW-1:0] pts;
  logic [N_CYL-1:0][1:0] err_hit;
  logic [SW-1:0] err_sum;

  crank_cfg_regs #(.N_CYL(N_CYL), .TW(TW), .AW(AW), .DEF_MOD(DEF_MOD)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .armed_o(armed), .mod_o(mod_q), .pts_o(pts)
  );

  crank_tick_ctr #(.TW(TW)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(armed), .tick_i(tick_i),
    .mod_i(mod_q), .cnt_o(tick_cnt_o), .wrap_o(wrap)
  );

  for (genvar c = 0; c < N_CYL; c++) begin : g_chan
    crank_event_chan #(.TW(TW)) u_chan (
      .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(armed), .wrap_i(wrap),
      .cnt_i(tick_cnt_o), .pts_i(pts[c]), .inj_o(inj_o[c]), .coil_o(coil_o[c]),
      .late_o(late_o[c]), .err_hit_o(err_hit[c])
    );
  end

  always_comb begin
    err_sum = {5'b0, err_cnt_o};
    for (int c = 0; c < N_CYL; c++) begin
      err_sum = err_sum + SW'(err_hit[c][0]) + SW'(err_hit[c][1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                err_cnt_o <= '0;
    else if (err_sum > {5'b0, {ERR_W{1'b1}}})   err_cnt_o <= '1;
    else                                        err_cnt_o <= err_sum[ERR_W-1:0];
  end
endmodule

// File: rtl/crank_event_sched_chk.sv
module crank_event_sched_chk
  import crank_sched_pkg::*;
#(
  parameter int unsigned N_CYL = 4,
  parameter int unsigned TW = 16,
  parameter int unsigned ERR_W = 8,
  parameter int unsigned AW = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic wr_en_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [TW-1:0] tick_cnt_o,
  input logic [N_CYL-1:0] inj_o,
  input logic [N_CYL-1:0] coil_o,
  input logic [N_CYL-1:0] late_o,
  input logic [ERR_W-1:0] err_cnt_o,
  input logic armed,
  input logic [TW-1:0] mod_q,
  input logic [N_CYL-1:0][EV_N-1:0][TW-1:0] pts
);
  logic commit_w;
  assign commit_w = wr_en_i && (wr_addr_i == AW'(A_COMMIT));

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && tick_i && (({1'b0, tick_cnt_o} + 1'b1) < {1'b0, mod_q}))
      |=> tick_cnt_o == $past(tick_cnt_o) + TW'(1));

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tick_cnt_o));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (tick_cnt_o == '0 && inj_o == '0 && coil_o == '0 && late_o == '0));

  assert_err_mono_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |=> err_cnt_o >= $past(err_cnt_o));

  assert_pts_buffered_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_w |=> $stable(pts));

  assert_late_needs_arm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (late_o != '0) |-> armed);
endmodule

bind crank_event_sched crank_event_sched_chk #(
  .N_CYL(N_CYL), .TW(TW), .ERR_W(ERR_W), .AW(AW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .tick_cnt_o(tick_cnt_o), .inj_o(inj_o), .coil_o(coil_o),
  .late_o(late_o), .err_cnt_o(err_cnt_o), .armed(armed), .mod_q(mod_q), .pts(pts)
);

// File: tb/crank_event_sched_test.sv
`timescale 1ns/1ps
module crank_event_sched_test;
  localparam int NC = 4;
  localparam int TW = 16;
  localparam int EW = 8;
  localparam int AW = $clog2(8 + 4*NC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [TW-1:0] wr_data = '0;
  logic [TW-1:0] cnt;
  logic [NC-1:0] inj, coil, late;
  logic [EW-1:0] err;

  always #2 clk = ~clk;

  crank_event_sched #(.N_CYL(NC), .TW(TW), .ERR_W(EW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_cnt_o(cnt), .inj_o(inj), .coil_o(coil),
    .late_o(late), .err_cnt_o(err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // behavioural reference
  int m_mod, s_mod, s_base, s_w, s_d, m_cnt, m_err;
  int s_ofs[NC], s_fu[NC], s_sp[NC];
  int m_pt[NC][4];
  bit m_done[NC][4], m_fire[NC][4];
  bit m_inj[NC], m_coil[NC], m_late[NC];
  bit m_armed, m_wrap;

  function automatic int madd(int a, int b, int m);
    return (a + b >= m) ? a + b - m : a + b;
  endfunction
  function automatic int msub(int a, int b, int m);
    return (a >= b) ? a - b : a + m - b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mod = 720; s_mod = 720; s_base = 0; s_w = 0; s_d = 0; m_cnt = 0; m_err = 0; m_armed = 0;
      for (int c = 0; c < NC; c++) begin
        s_ofs[c] = 0; s_fu[c] = 0; s_sp[c] = 0;
        m_inj[c] = 0; m_coil[c] = 0; m_late[c] = 0;
        for (int e = 0; e < 4; e++) begin m_pt[c][e] = 0; m_done[c][e] = 0; end
      end
    end else begin
      m_wrap = m_armed && tick && (m_cnt + 1 >= m_mod);
      for (int c = 0; c < NC; c++) begin
        bit lt;
        lt = 0;
        for (int e = 0; e < 4; e++) begin
          m_fire[c][e] = m_armed && !m_done[c][e] && (m_pt[c][e] <= m_cnt);
          if (m_fire[c][e] && m_pt[c][e] < m_cnt) lt = 1;
        end
        m_late[c] = lt;
        if (m_fire[c][0] && m_pt[c][0] == m_pt[c][1]) m_err++;
        if (m_fire[c][2] && m_pt[c][2] == m_pt[c][3]) m_err++;
        if (m_fire[c][1]) m_inj[c] = 0; else if (m_fire[c][0]) m_inj[c] = 1;
        if (m_fire[c][3]) m_coil[c] = 0; else if (m_fire[c][2]) m_coil[c] = 1;
        for (int e = 0; e < 4; e++) m_done[c][e] = m_wrap ? 0 : (m_done[c][e] | m_fire[c][e]);
      end
      if (m_err > 255) m_err = 255;
      if (m_armed && tick) m_cnt = m_wrap ? 0 : m_cnt + 1;
      if (wr_en) begin
        int a;
        a = int'(wr_addr);
        case (a)
          0: s_mod = int'(wr_data);
          1: s_base = int'(wr_data);
          2: s_w = int'(wr_data);
          3: s_d = int'(wr_data);
          4: begin
            m_mod = s_mod; m_armed = 1;
            for (int c = 0; c < NC; c++) begin
              int st, sp;
              st = madd(s_base, s_ofs[c], s_mod);
              sp = madd(st, s_sp[c], s_mod);
              m_pt[c][0] = st;
              m_pt[c][1] = madd(madd(st, s_w, s_mod), s_fu[c], s_mod);
              m_pt[c][3] = sp;
              m_pt[c][2] = msub(sp, s_d, s_mod);
            end
          end
          default: if (a >= 8) begin
            if ((a - 8) % 4 == 0) s_ofs[(a - 8) / 4] = int'(wr_data);
            if ((a - 8) % 4 == 1) s_fu[(a - 8) / 4] = int'(wr_data);
            if ((a - 8) % 4 == 2) s_sp[(a - 8) / 4] = int'(wr_data);
          end
        endcase
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 tick count", int'(cnt), m_cnt);
      chk("R7 error count", int'(err), m_err);
      for (int c = 0; c < NC; c++) begin
        chk($sformatf("R1 inj[%0d]", c), int'(inj[c]), int'(m_inj[c]));
        chk($sformatf("R1 coil[%0d]", c), int'(coil[c]), int'(m_coil[c]));
        chk($sformatf("R5 late[%0d]", c), int'(late[c]), int'(m_late[c]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      report();
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = TW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (i % 3 != 0);
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wait_cnt(int v);
    forever begin
      @(negedge clk);
      if (int'(cnt) == v) begin tick = 1'b0; break; end
      tick = 1'b1;
    end
  endtask

  int e0;

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset count", int'(cnt), 0);
    chk("R9 reset inj", int'(inj), 0);
    chk("R9 reset coil", int'(coil), 0);
    rst_n = 1'b1;
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    chk("R9 idle count before commit", int'(cnt), 0);

    // modulus 100, base 10, pulse 8, dwell 5, offsets 20c, fuel c, spark 30
    wr(0, 100); wr(1, 10); wr(2, 8); wr(3, 5);
    for (int c = 0; c < NC; c++) begin
      wr(8 + 4*c, 20*c); wr(9 + 4*c, c); wr(10 + 4*c, 30);
    end
    chk("R6 no output before commit", int'(inj | coil), 0);
    wr(4, 16'hBEEF);

    // R4: output one clock after counter reaches the point
    wait_cnt(10);
    chk("R4 inj[0] not yet on", int'(inj[0]), 0);
    @(negedge clk);
    chk("R4 inj[0] on", int'(inj[0]), 1);
    wait_cnt(18);
    chk("R1 inj[0] still on at off point", int'(inj[0]), 1);
    @(negedge clk);
    chk("R1 inj[0] off", int'(inj[0]), 0);

    // R3: dwell at 95 wraps into spark at 0
    wait_cnt(95);
    @(negedge clk);
    chk("R3 coil[3] dwell start", int'(coil[3]), 1);
    wait_cnt(0);
    @(negedge clk);
    chk("R3 coil[3] spark after wrap", int'(coil[3]), 0);

    run(300);

    // R6: shadow write without commit
    wr(1, 50);
    run(200);
    wait_cnt(10);
    @(negedge clk);
    chk("R6 uncommitted base ignored", int'(inj[0]), 1);
    wr(1, 10);

    // R5: move cylinder 3 start behind the count
    wait_cnt(60);
    wr(8 + 12, 40);
    wr(4, 0);
    @(negedge clk);
    chk("R5 inj[3] fired late", int'(inj[3]), 1);
    chk("R5 late[3] flag", int'(late[3]), 1);
    @(negedge clk);
    chk("R5 late[3] one clock", int'(late[3]), 0);

    // R7: cylinder 2 on and off points equal
    wr(9 + 8, 92);
    wr(4, 0);
    e0 = int'(err);
    wait_cnt(49);
    wait_cnt(52);
    chk("R7 inj[2] held low", int'(inj[2]), 0);
    chk("R7 error count bumped once", int'(err), e0 + 1);

    // R8: both cylinder 1 injector points behind the count
    wait_cnt(5);
    wr(12, 90); wr(13, 95);
    wr(4, 0);
    @(negedge clk);
    chk("R8 inj[1] ends low", int'(inj[1]), 0);
    chk("R8 late[1] flag", int'(late[1]), 1);

    run(400);
    report();
  end
endmodule